// File: doc/BRIEF.md
# Auxiliary-Clock Memory Streamer

This block sends the contents of a small byte memory, one bit at a time, on a single data line. The bits are paced by a slow auxiliary clock that is not related to the system clock. It serves the transmit-only identification path of a display: while the controller enables it and the bidirectional bus clock rests high, each rising edge of the auxiliary clock moves the line one bit further through the memory image.

After reset the line stays released for a fixed number of auxiliary edges. Streaming then starts at address zero. Each byte goes out most significant bit first, followed by one released slot. After the last address the stream returns to address zero and continues without a gap. The auxiliary clock passes through a synchroniser, and its rising edge is detected in the system clock domain. The memory is read through an external port, and the byte is registered ahead of use, so the line settles a fixed number of system clocks after each auxiliary edge.

When the mode controller withdraws the enable, the position returns to the first bit of address zero. The start-up window is not repeated. When the bus clock drops low, the line is released and the position is frozen until the bus clock is high again.

Top module: `aux_stream_tx`

## Requirements
- R1: While reset is asserted, and after it until the first counted edge, `sda_oe_o` is 0 and `rd_addr_o` is 0.
- R2: The first 9 auxiliary rising edges seen while active (`enable_i`=1 and `bus_idle_i`=1) after reset leave `sda_oe_o` at 0.
- R3: The 10th such edge sets `sda_oe_o`=1 and makes `sda_o` equal to bit 7 of the byte at address 0.
- R4: Each following edge presents the next bit of the current byte, in the order bit 7 down to bit 0, with `sda_oe_o`=1 and `sda_o` equal to that bit.
- R5: The edge after bit 0 of a byte is a null slot: `sda_oe_o`=0. The next edge starts bit 7 of the following address.
- R6: After the byte at address 127 has been sent, streaming continues with bit 7 of address 0, with no extra slot.
- R7: While `bus_idle_i`=0, `sda_oe_o` is 0 from the next clock, auxiliary edges are not counted and `rd_addr_o` holds. When `bus_idle_i` returns to 1, the stream resumes at the held position.
- R8: While `enable_i`=0, `sda_oe_o` is 0 and `rd_addr_o` goes to 0 on the next clock. After re-enable, the first edge drives bit 7 of address 0 and no new start-up window is inserted.
- R9: `rd_addr_o` gives the address of the byte whose bits are being sent or are next to be sent. `rd_data_i` is expected to return that byte combinationally.
- R10: The outputs change only in the third system clock after an auxiliary rising edge. Falling edges and the time between edges leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-up) |
| aux_clk_i | input | 1 | Auxiliary bit clock, asynchronous to clk_i |
| bus_idle_i | input | 1 | High while the bidirectional bus clock rests high |
| enable_i | input | 1 | Streaming permitted by the mode controller |
| rd_addr_o | output | 7 | Memory read address |
| rd_data_i | input | 8 | Memory read data for rd_addr_o |
| sda_oe_o | output | 1 | Data line output enable (0 = released) |
| sda_o | output | 1 | Data line value while enabled |

## Verification
Several internal faults show up at the ports, each within a bounded time:
- A start-up counter that is off by one moves the whole stream one slot, so the first data bit at the tenth edge is wrong or is released.
- A wrong bit order or a dropped null slot makes the pattern disagree with the memory image within one nine-edge frame.
- A broken wrap shows up only after all 128 bytes, on the first bit after address 127. The stream is therefore run past that point.
- A position that is not held or cleared shows up on the first edge after the bus clock returns high or after re-enable.

// File: rtl/aux_stream_pkg.sv
package aux_stream_pkg;
  typedef struct packed {
    logic oe;
    logic val;
  } line_t;

  localparam line_t LINE_RELEASED = '{oe: 1'b0, val: 1'b1};
endpackage

// File: rtl/aux_edge_sync.sv
module aux_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  // STAGES synchroniser flops plus one history flop
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/stream_seq.sv
module stream_seq #(
  parameter int DEPTH      = 128,
  parameter int DATA_W     = 8,
  parameter int INIT_EDGES = 9,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int SLOT_W = $clog2(DATA_W + 1),
  localparam int WIN_W  = $clog2(INIT_EDGES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              clear_i,
  output logic              win_open_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SLOT_W-1:0] slot_o
);
  localparam logic [WIN_W-1:0]  WIN_END  = WIN_W'(INIT_EDGES);
  localparam logic [SLOT_W-1:0] SLOT_END = SLOT_W'(DATA_W);
  localparam logic [ADDR_W-1:0] ADDR_END = ADDR_W'(DEPTH - 1);

  logic [WIN_W-1:0]  win_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SLOT_W-1:0] slot_q;

  assign win_open_o = (win_q != WIN_END);
  assign addr_o     = addr_q;
  assign slot_o     = slot_q;

  // start-up window counts only on active edges, cleared only by reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  win_q <= '0;
    else if (step_i && win_open_o) win_q <= win_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      slot_q <= '0;
    end else if (clear_i) begin
      addr_q <= '0;
      slot_q <= '0;
    end else if (step_i && !win_open_o) begin
      if (slot_q == SLOT_END) begin
        slot_q <= '0;
        addr_q <= (addr_q == ADDR_END) ? '0 : addr_q + 1'b1;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bit_select.sv
module bit_select
  import aux_stream_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int SLOT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              win_open_i,
  input  logic              step_i,
  input  logic              active_i,
  output line_t             line_o
);
  localparam logic [SLOT_W-1:0] SLOT_END = SLOT_W'(DATA_W);

  logic [DATA_W-1:0] byte_q;
  logic [DATA_W-1:0] shifted;
  line_t             line_q;
  line_t             line_d;

  // byte fetched one clock ahead of any step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) byte_q <= '0;
    else         byte_q <= rd_data_i;
  end

  assign shifted = byte_q << slot_i;

  always_comb begin
    line_d = line_q;
    if (!active_i) begin
      line_d = LINE_RELEASED;
    end else if (step_i) begin
      if (win_open_i || slot_i == SLOT_END) line_d = LINE_RELEASED;
      else line_d = '{oe: 1'b1, val: shifted[DATA_W-1]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= LINE_RELEASED;
    else         line_q <= line_d;
  end

  assign line_o = line_q;
endmodule

// File: rtl/aux_stream_tx.sv
module aux_stream_tx
  import aux_stream_pkg::*;
#(
  parameter int DEPTH       = 128,
  parameter int DATA_W      = 8,
  parameter int INIT_EDGES  = 9,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int SLOT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              aux_clk_i,
  input  logic              bus_idle_i,
  input  logic              enable_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              sda_o
);
  logic              aux_rise;
  logic              active;
  logic              step;
  logic              win_open;
  logic [SLOT_W-1:0] slot;
  line_t             line;

  assign active = enable_i & bus_idle_i;
  assign step   = aux_rise & active;

  aux_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(aux_clk_i),
    .rise_o (aux_rise)
  );

  stream_seq #(
    .DEPTH     (DEPTH),
    .DATA_W    (DATA_W),
    .INIT_EDGES(INIT_EDGES)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .clear_i   (~enable_i),
    .win_open_o(win_open),
    .addr_o    (rd_addr_o),
    .slot_o    (slot)
  );

  bit_select #(.DATA_W(DATA_W)) u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_data_i (rd_data_i),
    .slot_i    (slot),
    .win_open_i(win_open),
    .step_i    (step),
    .active_i  (active),
    .line_o    (line)
  );

  assign sda_oe_o = line.oe;
  assign sda_o    = line.val;
endmodule

// File: rtl/aux_stream_chk.sv
module aux_stream_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_idle_i,
  input logic              enable_i,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              sda_oe_o,
  input logic              sda_o,
  input logic              aux_rise_i,
  input logic              win_open_i
);
  a_r2_window_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_open_i |-> !sda_oe_o);

  a_r6_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rd_addr_o) |-> (rd_addr_o == '0 || rd_addr_o == $past(rd_addr_o) + 1'b1));

  a_r7_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_idle_i |=> !sda_oe_o);

  a_r7_idle_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_idle_i && enable_i) |=> $stable(rd_addr_o));

  a_r8_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (rd_addr_o == '0 && !sda_oe_o));

  a_r10_quiet_no_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!aux_rise_i && enable_i && bus_idle_i) |=> ($stable(sda_oe_o) && $stable(sda_o)));
endmodule

bind aux_stream_tx aux_stream_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bus_idle_i(bus_idle_i),
  .enable_i  (enable_i),
  .rd_addr_o (rd_addr_o),
  .sda_oe_o  (sda_oe_o),
  .sda_o     (sda_o),
  .aux_rise_i(aux_rise),
  .win_open_i(win_open)
);

// File: tb/aux_stream_tx_tb_top.sv
`timescale 1ns/1ps
module aux_stream_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       aux;
  logic       idle;
  logic       en;
  logic [6:0] rd_addr;
  logic [7:0] rd_data;
  logic       sda_oe;
  logic       sda;

  logic [7:0] mem [128];

  int  errors = 0;
  int  checks = 0;
  bit  done   = 1'b0;

  int    m_win, m_addr, m_slot;
  bit    m_first, m_wrapped;
  logic  exp_oe, exp_val;
  string m_tag;

  always #2 clk = ~clk;

  assign rd_data = mem[rd_addr];

  aux_stream_tx dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .aux_clk_i (aux),
    .bus_idle_i(idle),
    .enable_i  (en),
    .rd_addr_o (rd_addr),
    .rd_data_i (rd_data),
    .sda_oe_o  (sda_oe),
    .sda_o     (sda)
  );

  task automatic check_line(input string req, input logic oe_e, input logic val_e);
    checks++;
    if (sda_oe !== oe_e || (oe_e && sda !== val_e)) begin
      errors++;
      $display("FAIL %s: oe=%b val=%b expected oe=%b val=%b", req, sda_oe, sda, oe_e, val_e);
    end
  endtask

  task automatic check_addr(input string req, input logic [6:0] exp_a);
    checks++;
    if (rd_addr !== exp_a) begin
      errors++;
      $display("FAIL %s: rd_addr=%0d expected %0d", req, rd_addr, exp_a);
    end
  endtask

  // reference model of one counted auxiliary edge
  task automatic model_step();
    if (m_win < 9) begin
      m_win++;
      exp_oe = 1'b0;
      m_tag  = "R2";
    end else begin
      if (m_slot == 8) begin
        exp_oe = 1'b0;
        m_tag  = "R5";
      end else begin
        exp_oe  = 1'b1;
        exp_val = mem[m_addr][7-m_slot];
        m_tag   = m_first ? "R3" : (m_wrapped ? "R6" : "R4");
        m_first = 1'b0;
      end
      m_slot++;
      if (m_slot == 9) begin
        m_slot = 0;
        m_addr = (m_addr + 1) % 128;
        if (m_addr == 0) m_wrapped = 1'b1;
      end
    end
  endtask

  task automatic pulse(input string ovr, input bit counted);
    string tag;
    aux = 1'b1;
    repeat (3) @(negedge clk);
    if (counted) model_step();
    else exp_oe = 1'b0;
    tag = (ovr != "") ? ovr : m_tag;
    check_line(tag, exp_oe, exp_val);
    repeat ($urandom_range(1, 4)) @(negedge clk);
    aux = 1'b0;
    repeat (3) @(negedge clk);
    check_line("R10", exp_oe, exp_val);
    repeat ($urandom_range(0, 3)) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h1d5e_ed01));
    for (int i = 0; i < 128; i++) mem[i] = 8'($urandom);
    mem[0]   = 8'b1011_0010;
    mem[127] = 8'b0110_1101;
    m_win = 0; m_addr = 0; m_slot = 0; m_first = 1'b1; m_wrapped = 1'b0;
    exp_oe = 1'b0; exp_val = 1'b1; m_tag = "R2";
    rst_n = 1'b0; aux = 1'b0; idle = 1'b1; en = 1'b1;
    repeat (5) @(negedge clk);
    check_line("R1", 1'b0, 1'b1);
    check_addr("R1", 7'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_line("R1", 1'b0, 1'b1);

    // window, first bit, full image, wrap and part of the second pass
    for (int i = 0; i < 9 + 9 * 130; i++) pulse("", 1'b1);
    check_addr("R9", 7'(m_addr));

    // bus clock low: frozen and released
    idle = 1'b0;
    repeat (3) @(negedge clk);
    check_line("R7", 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) pulse("R7", 1'b0);
    check_addr("R7", 7'(m_addr));
    idle = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4; i++) pulse("R7", 1'b1);

    // disable: position cleared, no new window on return
    en = 1'b0;
    repeat (3) @(negedge clk);
    check_line("R8", 1'b0, 1'b1);
    check_addr("R8", 7'd0);
    for (int i = 0; i < 2; i++) pulse("R8", 1'b0);
    en = 1'b1;
    m_addr = 0; m_slot = 0;
    repeat (2) @(negedge clk);
    pulse("R8", 1'b1);
    for (int i = 0; i < 30; i++) pulse("", 1'b1);
    check_addr("R9", 7'(m_addr));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule